// File: doc/BRIEF.md
# Zero-Count Table Append Unit

This unit keeps the write cursor of a zero-count table and appends 32-bit header pointers to it. The table is a chain of fixed-size blocks in word-addressed memory. Each append writes the header pointer as a doubleword at the cursor and hands back the caller's header word with its top bit set, which marks the object as listed. Normally the cursor then moves up by two words. When the doubleword just written sits at the last entry slot of a block (low 11 address bits equal to 0x7FC), the cursor does not move by two. The unit reads the link doubleword that follows that slot and jumps to the block the link names.

A one-bit marking flag is held beside the cursor and is never touched by a block jump. A load operation fills the cursor and the flag from a table descriptor and enables appends. A save operation writes the cursor back into the descriptor and disables appends. Operations use a request/acknowledge handshake. Memory is reached through a doubleword read/write port that also uses request/acknowledge.

The control is a single state machine:
- S_IDLE accepts an operation. It goes to S_APPEND_WR, S_LOAD_PTR or S_SAVE_WR, or it goes straight to S_REPLY when the operation traps at once.
- S_APPEND_WR goes to S_LINK_RD at the end of a block, and to S_REPLY otherwise.
- S_LINK_RD goes to S_REPLY.
- S_LOAD_PTR goes to S_LOAD_FLAG, or to S_REPLY on an odd pointer.
- S_LOAD_FLAG and S_SAVE_WR go to S_REPLY.
- S_REPLY returns to S_IDLE.

Top module: `zct_append_unit`

## Requirements
- R1: After reset the unit is disabled, the marking flag is 0, and no memory request, acknowledge or busy is asserted.
- R2: An append (op_code 0) while disabled ends with op_trap=1 and trap_code=2, and performs no memory write.
- R3: A load (op_code 1) or save (op_code 2) whose base has any of its low 8 bits set traps with code 5 and writes nothing. A load that reads an odd pointer traps with code 5 and leaves the unit disabled.
- R4: A successful load takes the cursor from the doubleword at the base (the word at the lower address is the upper 16 bits). It takes the flag from the least significant bit of the word at base+6, and it enables appends.
- R5: An append writes the header pointer as a doubleword at the cursor (upper half at the cursor address) and then advances the cursor by 2.
- R6: A completed append returns the caller's 16-bit header word with bit 15 set and all other bits unchanged.
- R7: When the append slot has low 11 bits equal to 0x7FC, the unit reads the doubleword at cursor+2 with busy high. A valid link becomes the new cursor.
- R8: A link of zero traps with code 4 and leaves the cursor unchanged. The entry itself has already been written.
- R9: An odd link traps with code 5 and leaves the cursor unchanged. The cursor is always even.
- R10: The marking flag keeps its value across every block jump.
- R11: A save writes the cursor as a doubleword at the base and disables appends.
- R12: A memory request holds its address and direction stable until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_valid | input | 1 | Operation request, held until op_ack |
| op_code | input | 2 | 0 append, 1 load, 2 save |
| op_hdr_ptr | input | 32 | Header pointer to append |
| op_hdr_word | input | 16 | Caller's first header word |
| op_base | input | 32 | Descriptor base address for load/save |
| op_ack | output | 1 | One-cycle completion pulse |
| op_trap | output | 1 | Operation trapped (valid with op_ack) |
| trap_code | output | 3 | Trap code (2 disabled, 4 table full, 5 internal) |
| hdr_out | output | 16 | Header word with listed bit set |
| busy | output | 1 | Link fetch outstanding |
| enabled | output | 1 | Appends allowed |
| mark_flag | output | 1 | Marking flag |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | 32 | Word address of the doubleword |
| mem_wdata | output | 32 | Write doubleword |
| mem_ack | input | 1 | Memory completion |
| mem_rdata | input | 32 | Read doubleword, valid with mem_ack |

## Verification
An append to the last slot of a block both stores an entry and starts a link fetch. That is the cycle where the entry write, the cursor update and a trap can meet. The bench steers the cursor onto the 0x7FC slot with three kinds of link: valid, zero and odd. For each, it checks that the entry landed in memory, that busy was seen, and where the cursor went. The cursor is read back through the address of the next append or through a save, and the flag is read back at the port after each jump.

// File: rtl/zct_pkg.sv
package zct_pkg;
    typedef enum logic [1:0] {
        OP_APPEND = 2'd0,
        OP_LOAD   = 2'd1,
        OP_SAVE   = 2'd2,
        OP_NONE   = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_APPEND_WR,
        S_LINK_RD,
        S_LOAD_PTR,
        S_LOAD_FLAG,
        S_SAVE_WR,
        S_REPLY
    } state_e;

    localparam logic [2:0] TRAP_NONE     = 3'd0;
    localparam logic [2:0] TRAP_DISABLED = 3'd2;
    localparam logic [2:0] TRAP_FULL     = 3'd4;
    localparam logic [2:0] TRAP_INTERNAL = 3'd5;
endpackage

// File: rtl/zct_block_end.sv
module zct_block_end #(
    parameter int ADDR_W     = 32,
    parameter int BLOCK_BITS = 11
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              at_end
);
    localparam logic [BLOCK_BITS-1:0] LAST_SLOT =
        BLOCK_BITS'((1 << BLOCK_BITS) - 4);

    always_comb at_end = (addr[BLOCK_BITS-1:0] == LAST_SLOT);
endmodule

// File: rtl/zct_page_check.sv
module zct_page_check #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              aligned
);
    always_comb aligned = (addr[PAGE_BITS-1:0] == '0);
endmodule

// File: rtl/zct_ptr_state.sv
module zct_ptr_state #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_load,
    input  logic [ADDR_W-1:0] wp_next,
    input  logic              flag_load,
    input  logic              flag_next,
    input  logic              en_set,
    input  logic              en_clr,
    output logic [ADDR_W-1:0] wp,
    output logic              mark_flag,
    output logic              enabled
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp        <= '0;
            mark_flag <= 1'b0;
            enabled   <= 1'b0;
        end else begin
            if (wp_load)   wp        <= wp_next;
            if (flag_load) mark_flag <= flag_next;
            if (en_set)    enabled   <= 1'b1;
            else if (en_clr) enabled <= 1'b0;
        end
    end

    // R9: the cursor never holds an odd address
    a_r9_ptr_even: assert property (@(posedge clk) disable iff (!rst_n)
        !wp[0]);
endmodule

// File: rtl/zct_append_unit.sv
module zct_append_unit
    import zct_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int BLOCK_BITS = 11,
    parameter int PAGE_BITS  = 8,
    parameter int FLAG_OFS   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [1:0]          op_code,
    input  logic [2*WORD_W-1:0] op_hdr_ptr,
    input  logic [WORD_W-1:0]   op_hdr_word,
    input  logic [2*WORD_W-1:0] op_base,
    output logic                op_ack,
    output logic                op_trap,
    output logic [2:0]          trap_code,
    output logic [WORD_W-1:0]   hdr_out,
    output logic                busy,
    output logic                enabled,
    output logic                mark_flag,
    output logic                mem_req,
    output logic                mem_we,
    output logic [2*WORD_W-1:0] mem_addr,
    output logic [2*WORD_W-1:0] mem_wdata,
    input  logic                mem_ack,
    input  logic [2*WORD_W-1:0] mem_rdata
);
    localparam int ADDR_W = 2 * WORD_W;
    localparam logic [WORD_W-1:0] LISTED = WORD_W'(1) << (WORD_W - 1);

    state_e              state_q, state_d;
    op_e                 op_q;
    logic [ADDR_W-1:0]   ptr_q, base_q, cand_q;
    logic [WORD_W-1:0]   hword_q;
    logic                res_trap_q, res_trap_d;
    logic [2:0]          res_code_q, res_code_d;
    logic                res_set, cand_load;

    logic [ADDR_W-1:0]   wp, wp_next;
    logic                wp_load, flag_load, flag_next, en_set, en_clr;
    logic                at_end, base_ok;

    zct_ptr_state #(.ADDR_W(ADDR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .wp_load(wp_load), .wp_next(wp_next),
        .flag_load(flag_load), .flag_next(flag_next),
        .en_set(en_set), .en_clr(en_clr),
        .wp(wp), .mark_flag(mark_flag), .enabled(enabled)
    );

    zct_block_end #(.ADDR_W(ADDR_W), .BLOCK_BITS(BLOCK_BITS)) u_end (
        .addr(wp), .at_end(at_end)
    );

    zct_page_check #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_page (
        .addr(op_base), .aligned(base_ok)
    );

    // State register and captured operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            op_q       <= OP_NONE;
            ptr_q      <= '0;
            base_q     <= '0;
            cand_q     <= '0;
            hword_q    <= '0;
            res_trap_q <= 1'b0;
            res_code_q <= TRAP_NONE;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && op_valid) begin
                op_q    <= op_e'(op_code);
                ptr_q   <= op_hdr_ptr;
                base_q  <= op_base;
                hword_q <= op_hdr_word;
            end
            if (cand_load) cand_q <= mem_rdata;
            if (res_set) begin
                res_trap_q <= res_trap_d;
                res_code_q <= res_code_d;
            end
        end
    end

    // Next state, memory requests and pointer updates
    always_comb begin
        state_d    = state_q;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        wp_load    = 1'b0;
        wp_next    = wp;
        flag_load  = 1'b0;
        flag_next  = mark_flag;
        en_set     = 1'b0;
        en_clr     = 1'b0;
        res_set    = 1'b0;
        res_trap_d = 1'b0;
        res_code_d = TRAP_NONE;
        cand_load  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (op_valid) begin
                    unique case (op_e'(op_code))
                        OP_APPEND: begin
                            if (!enabled) begin
                                res_set    = 1'b1;
                                res_trap_d = 1'b1;
                                res_code_d = TRAP_DISABLED;
                                state_d    = S_REPLY;
                            end else begin
                                state_d = S_APPEND_WR;
                            end
                        end
                        OP_LOAD, OP_SAVE: begin
                            if (!base_ok) begin
                                res_set    = 1'b1;
                                res_trap_d = 1'b1;
                                res_code_d = TRAP_INTERNAL;
                                state_d    = S_REPLY;
                            end else if (op_e'(op_code) == OP_LOAD) begin
                                state_d = S_LOAD_PTR;
                            end else begin
                                state_d = S_SAVE_WR;
                            end
                        end
                        default: begin
                            res_set = 1'b1;
                            state_d = S_REPLY;
                        end
                    endcase
                end
            end
            S_APPEND_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = wp;
                mem_wdata = ptr_q;
                if (mem_ack) begin
                    if (at_end) begin
                        state_d = S_LINK_RD;
                    end else begin
                        wp_load = 1'b1;
                        wp_next = wp + ADDR_W'(2);
                        res_set = 1'b1;
                        state_d = S_REPLY;
                    end
                end
            end
            S_LINK_RD: begin
                mem_req  = 1'b1;
                mem_addr = wp + ADDR_W'(2);
                if (mem_ack) begin
                    res_set = 1'b1;
                    state_d = S_REPLY;
                    if (mem_rdata == '0) begin
                        res_trap_d = 1'b1;
                        res_code_d = TRAP_FULL;
                    end else if (mem_rdata[0]) begin
                        res_trap_d = 1'b1;
                        res_code_d = TRAP_INTERNAL;
                    end else begin
                        wp_load = 1'b1;
                        wp_next = mem_rdata;
                    end
                end
            end
            S_LOAD_PTR: begin
                mem_req  = 1'b1;
                mem_addr = base_q;
                if (mem_ack) begin
                    if (mem_rdata[0]) begin
                        res_set    = 1'b1;
                        res_trap_d = 1'b1;
                        res_code_d = TRAP_INTERNAL;
                        state_d    = S_REPLY;
                    end else begin
                        cand_load = 1'b1;
                        state_d   = S_LOAD_FLAG;
                    end
                end
            end
            S_LOAD_FLAG: begin
                mem_req  = 1'b1;
                mem_addr = base_q + ADDR_W'(FLAG_OFS);
                if (mem_ack) begin
                    wp_load   = 1'b1;
                    wp_next   = cand_q;
                    flag_load = 1'b1;
                    flag_next = mem_rdata[WORD_W];
                    en_set    = 1'b1;
                    res_set   = 1'b1;
                    state_d   = S_REPLY;
                end
            end
            S_SAVE_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = base_q;
                mem_wdata = wp;
                if (mem_ack) begin
                    en_clr  = 1'b1;
                    res_set = 1'b1;
                    state_d = S_REPLY;
                end
            end
            S_REPLY: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Handshake outputs
    always_comb begin
        op_ack    = (state_q == S_REPLY);
        op_trap   = res_trap_q;
        trap_code = res_code_q;
        hdr_out   = hword_q | LISTED;
        busy      = (state_q == S_LINK_RD);
    end

    // R12: request held stable until acknowledged
    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R5: a plain append moves the cursor by exactly two words
    a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_APPEND_WR && mem_ack && !at_end) |=> (wp == $past(wp) + ADDR_W'(2)));

    // R8: a trapped operation leaves the cursor where it was
    a_r8_trap_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (op_ack && op_trap) |-> (wp == $past(wp)));

    // R10: the marking flag survives the block jump
    a_r10_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LINK_RD) |=> (mark_flag == $past(mark_flag)));

    // R7: busy only while a read is outstanding
    a_r7_busy_is_read: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (mem_req && !mem_we));
endmodule

// File: tb/test_zct_append_unit.sv
module test_zct_append_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = 2'd3;
    logic [31:0] op_hdr_ptr = '0;
    logic [15:0] op_hdr_word = '0;
    logic [31:0] op_base = '0;
    logic        op_ack, op_trap, busy, enabled, mark_flag;
    logic [2:0]  trap_code;
    logic [15:0] hdr_out;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    zct_append_unit i_zct_append_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_hdr_ptr(op_hdr_ptr), .op_hdr_word(op_hdr_word), .op_base(op_base),
        .op_ack(op_ack), .op_trap(op_trap), .trap_code(trap_code),
        .hdr_out(hdr_out), .busy(busy), .enabled(enabled), .mark_flag(mark_flag),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Memory model: 64K words, one-cycle response, poke port for setup
    logic [15:0] mem [0:65535];
    int          wr_cnt = 0;
    logic        poke_en = 1'b0;
    logic [15:0] poke_a = '0;
    logic [15:0] poke_d = '0;

    always @(posedge clk) begin
        if (poke_en) mem[poke_a] <= poke_d;
        if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (mem_we) begin
                mem[mem_addr[15:0]]          <= mem_wdata[31:16];
                mem[mem_addr[15:0] + 16'd1]  <= mem_wdata[15:0];
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= {mem[mem_addr[15:0]], mem[mem_addr[15:0] + 16'd1]};
            end
            mem_ack <= 1'b1;
        end
    end

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic poke(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        poke_a  = a;
        poke_d  = d;
        poke_en = 1'b1;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic poke_dw(input logic [15:0] a, input logic [31:0] d);
        poke(a, d[31:16]);
        poke(a + 16'd1, d[15:0]);
    endtask

    function automatic logic [31:0] peek_dw(input logic [15:0] a);
        return {mem[a], mem[a + 16'd1]};
    endfunction

    function automatic logic [15:0] exp_hdr(input logic [15:0] w);
        return w | 16'h8000;
    endfunction

    function automatic bit slot_is_last(input logic [31:0] a);
        return a[10:0] == 11'h7FC;
    endfunction

    logic        r_trap;
    logic [2:0]  r_code;
    logic [15:0] r_hdr;
    bit          r_busy;
    int          r_writes;

    task automatic do_op(input logic [1:0] code, input logic [31:0] hp,
                         input logic [15:0] hw, input logic [31:0] base);
        int w0;
        @(negedge clk);
        w0 = wr_cnt;
        op_code     = code;
        op_hdr_ptr  = hp;
        op_hdr_word = hw;
        op_base     = base;
        op_valid    = 1'b1;
        r_busy      = 1'b0;
        @(negedge clk);
        while (!op_ack) begin
            if (busy) r_busy = 1'b1;
            @(negedge clk);
        end
        r_trap   = op_trap;
        r_code   = trap_code;
        r_hdr    = hdr_out;
        op_valid = 1'b0;
        @(negedge clk);
        r_writes = wr_cnt - w0;
    endtask

    logic [31:0] exp_wp;

    task automatic append_ok(input logic [31:0] hp, input logic [15:0] hw, input string tag);
        logic [31:0] at;
        at = exp_wp;
        do_op(2'd0, hp, hw, 32'h0);
        chk(r_trap == 1'b0, "R5", {tag, " no trap"}, {29'd0, r_code}, 32'd0);
        chk(peek_dw(at[15:0]) == hp, "R5", {tag, " entry stored"}, peek_dw(at[15:0]), hp);
        chk(r_hdr == exp_hdr(hw), "R6", {tag, " header marked"}, {16'd0, r_hdr}, {16'd0, exp_hdr(hw)});
        if (slot_is_last(at)) exp_wp = peek_dw(at[15:0] + 16'd2);
        else                  exp_wp = at + 32'd2;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 65536; i++) mem[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(enabled == 1'b0, "R1", "enabled after reset", {31'd0, enabled}, 32'd0);
        chk(mark_flag == 1'b0, "R1", "flag after reset", {31'd0, mark_flag}, 32'd0);
        chk(!mem_req && !op_ack && !busy, "R1", "idle outputs", {29'd0, mem_req, op_ack, busy}, 32'd0);

        // R2: append while disabled
        do_op(2'd0, 32'h1234_5678, 16'h0001, 32'h0);
        chk(r_trap && r_code == 3'd2, "R2", "disabled trap", {28'd0, r_trap, r_code}, {28'd1, 3'd2});
        chk(r_writes == 0, "R2", "no write when disabled", r_writes, 0);

        // R3: misaligned base on load
        do_op(2'd1, 32'h0, 16'h0, 32'h0000_1004);
        chk(r_trap && r_code == 3'd5, "R3", "misaligned load", {28'd0, r_trap, r_code}, {28'd1, 3'd5});

        // R3: odd pointer in descriptor
        poke_dw(16'h1000, 32'h0000_47F9);
        poke_dw(16'h1006, 32'h0001_0000);
        do_op(2'd1, 32'h0, 16'h0, 32'h0000_1000);
        chk(r_trap && r_code == 3'd5, "R3", "odd pointer load", {28'd0, r_trap, r_code}, {28'd1, 3'd5});
        chk(enabled == 1'b0, "R3", "still disabled", {31'd0, enabled}, 32'd0);

        // R4: good load, flag from LSB of word base+6
        poke_dw(16'h1000, 32'h0000_47F8);
        poke_dw(16'h47FE, 32'h0000_6000);
        do_op(2'd1, 32'h0, 16'h0, 32'h0000_1000);
        chk(!r_trap, "R4", "load ok", {31'd0, r_trap}, 32'd0);
        chk(enabled && mark_flag, "R4", "enabled and flag", {30'd0, enabled, mark_flag}, 32'd3);
        exp_wp = 32'h0000_47F8;

        // R5/R6: two plain appends, then R7 block jump
        append_ok(32'hAAAA_0002, 16'h0123, "first");
        chk(!r_busy, "R7", "no busy mid-block", {31'd0, r_busy}, 32'd0);
        append_ok(32'hBBBB_0004, 16'h8F00, "second");
        append_ok(32'hCCCC_0006, 16'h7FFF, "last slot");
        chk(r_busy, "R7", "busy during link fetch", {31'd0, r_busy}, 32'd1);
        chk(mark_flag == 1'b1, "R10", "flag 1 after jump", {31'd0, mark_flag}, 32'd1);
        chk(exp_wp == 32'h0000_6000, "R7", "model followed link", exp_wp, 32'h6000);

        // random appends inside the new block
        for (int k = 0; k < 20; k++) begin
            append_ok($urandom, 16'($urandom), "random");
        end

        // R11: save writes cursor and disables
        do_op(2'd2, 32'h0, 16'h0, 32'h0000_1000);
        chk(!r_trap && r_writes == 1, "R11", "save one write", r_writes, 1);
        chk(peek_dw(16'h1000) == exp_wp, "R11", "saved cursor", peek_dw(16'h1000), exp_wp);
        chk(enabled == 1'b0, "R11", "disabled after save", {31'd0, enabled}, 32'd0);
        do_op(2'd2, 32'h0, 16'h0, 32'h0000_1080);
        chk(r_trap && r_code == 3'd5 && r_writes == 0, "R3", "misaligned save",
            {28'd0, r_trap, r_code}, {28'd1, 3'd5});
        do_op(2'd0, 32'h1, 16'h0, 32'h0);
        chk(r_trap && r_code == 3'd2, "R2", "append after save", {28'd0, r_trap, r_code}, {28'd1, 3'd2});

        // R8: zero link, table full; flag 0 this time
        poke_dw(16'h2000, 32'h0000_27FC);
        poke_dw(16'h2006, 32'h0000_0000);
        do_op(2'd1, 32'h0, 16'h0, 32'h0000_2000);
        chk(!r_trap && enabled && !mark_flag, "R4", "second load flag 0",
            {30'd0, enabled, mark_flag}, 32'd2);
        do_op(2'd0, 32'hDEAD_0010, 16'h0, 32'h0);
        chk(r_trap && r_code == 3'd4, "R8", "table full trap", {28'd0, r_trap, r_code}, {28'd1, 3'd4});
        chk(peek_dw(16'h27FC) == 32'hDEAD_0010, "R8", "entry written before trap",
            peek_dw(16'h27FC), 32'hDEAD_0010);
        do_op(2'd0, 32'hBEEF_0012, 16'h0, 32'h0);
        chk(r_trap && r_code == 3'd4, "R8", "full again", {28'd0, r_trap, r_code}, {28'd1, 3'd4});
        chk(peek_dw(16'h27FC) == 32'hBEEF_0012, "R8", "cursor unchanged",
            peek_dw(16'h27FC), 32'hBEEF_0012);
        do_op(2'd2, 32'h0, 16'h0, 32'h0000_2000);
        chk(peek_dw(16'h2000) == 32'h0000_27FC, "R8", "saved cursor unchanged",
            peek_dw(16'h2000), 32'h27FC);

        // R9: odd link, then repaired link; R10 with flag 0
        poke_dw(16'h3000, 32'h0000_37FC);
        poke_dw(16'h3006, 32'h0000_0000);
        poke_dw(16'h37FE, 32'h0000_5001);
        do_op(2'd1, 32'h0, 16'h0, 32'h0000_3000);
        do_op(2'd0, 32'h1111_0020, 16'h0, 32'h0);
        chk(r_trap && r_code == 3'd5, "R9", "odd link trap", {28'd0, r_trap, r_code}, {28'd1, 3'd5});
        poke_dw(16'h37FE, 32'h0000_5000);
        exp_wp = 32'h0000_37FC;
        append_ok(32'h2222_0022, 16'h4000, "repaired link");
        chk(r_busy, "R7", "busy on repaired jump", {31'd0, r_busy}, 32'd1);
        chk(mark_flag == 1'b0, "R10", "flag 0 after jump", {31'd0, mark_flag}, 32'd0);
        append_ok(32'h3333_0024, 16'h0000, "first in new block");
        chk(peek_dw(16'h5000) == 32'h3333_0024, "R9", "cursor at new block",
            peek_dw(16'h5000), 32'h3333_0024);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule